// File: doc/BRIEF.md
# Saturating Counting Semaphore Cell

This block holds one 16-bit counting semaphore that several threads of a processor share. Each access comes with a view selector. The view decides whether a read consumes a unit of the count, whether a read may stall the thread, or whether the access goes to the cell's tag bits.

The take/give views give the usual semaphore behaviour. A read hands back the count it found and removes one unit, but the count never drops below zero. A write adds one unit and stops at 0xFFFF. Two take/give views exist:
- The waiting view reports a stall when the count is zero.
- The polling view returns zero in that case and leaves the count alone.

The raw view reads or loads the count as a plain register. The tag view reads and writes the Empty and Full tag bits, which no count operation ever touches.

A read and a write may arrive in the same cycle. The write is applied first, and the read then sees its result. Each result appears on the outputs one cycle after the request.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, both tag bits are 0, and `rsp_valid`, `rsp_stall` and `rsp_data` are all 0.
- R2: A read in either take/give view (view codes 2 = waiting, 3 = polling) of a non-zero count returns that count and leaves the count one lower.
- R3: A take/give read of a zero count never changes the count; a polling read of zero returns 0 with `rsp_valid` high.
- R4: A take/give write adds one to the count and holds it at 0xFFFF once it is there.
- R5: A waiting-view read of a zero count raises `rsp_stall` with `rsp_valid` low and `rsp_data` 0; a polling-view read never raises `rsp_stall`.
- R6: The tag bits (Empty = bit 0, Full = bit 1 of the data word) change only on a tag-view write (view code 1), which loads them from `wr_data[1:0]`. A tag-view read returns them zero-extended. Count operations and raw operations leave them as they were.
- R7: A raw-view read (view code 0) returns the count without changing it; a raw-view write loads `wr_data` into the count.
- R8: When a read and a write occur in the same cycle, the write takes effect first and the read operates on its result.
- R9: Every response appears on the cycle after the request. A cycle with no read gives `rsp_valid` and `rsp_stall` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request |
| rd_view | input | 2 | View of the read (0 raw, 1 tag, 2 waiting, 3 polling) |
| wr_req | input | 1 | Write request |
| wr_view | input | 2 | View of the write, same coding as the read |
| wr_data | input | 16 | Write data |
| rsp_valid | output | 1 | Read completed, data valid |
| rsp_stall | output | 1 | Read must wait: waiting view found zero |
| rsp_data | output | 16 | Read data, 0 when not valid |

## Verification
The hardest situations to reach from the ports are the count's two end points, especially the case where both end points meet a same-cycle read and write. From reset, climbing to 0xFFFF through take/give writes would take 65535 cycles. The stimulus therefore loads the count near its top with a raw write, then gives past the ceiling. At the floor, the stimulus pairs a waiting read of zero with a give in the same cycle. The read must then succeed and return 1 rather than stall. A second pairing at the ceiling confirms that the write saturates before the take.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned TAG_W = 2;

  typedef enum logic [1:0] {
    VIEW_RAW  = 2'd0,
    VIEW_TAG  = 2'd1,
    VIEW_WAIT = 2'd2,
    VIEW_POLL = 2'd3
  } view_e;

  function automatic logic is_pv(input view_e v);
    return (v == VIEW_WAIT) || (v == VIEW_POLL);
  endfunction
endpackage

// File: rtl/sem_write_stage.sv
module sem_write_stage
  import sem_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned TW = TAG_W
) (
  input  logic          wr_req,
  input  view_e         wr_view,
  input  logic [W-1:0]  wr_data,
  input  logic [W-1:0]  count_cur,
  input  logic [TW-1:0] tag_cur,
  output logic [W-1:0]  count_mid,
  output logic [TW-1:0] tag_mid,
  output logic          tag_load
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_comb begin
    count_mid = count_cur;
    tag_mid   = tag_cur;
    tag_load  = 1'b0;
    if (wr_req) begin
      unique case (wr_view)
        VIEW_RAW:  count_mid = wr_data;
        VIEW_TAG: begin
          tag_mid  = wr_data[TW-1:0];
          tag_load = 1'b1;
        end
        default:   count_mid = (count_cur == CNT_MAX) ? CNT_MAX : count_cur + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sem_read_stage.sv
module sem_read_stage
  import sem_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned TW = TAG_W
) (
  input  logic          rd_req,
  input  view_e         rd_view,
  input  logic [W-1:0]  count_mid,
  input  logic [TW-1:0] tag_mid,
  output logic [W-1:0]  count_nxt,
  output logic [W-1:0]  data_nxt,
  output logic          valid_nxt,
  output logic          stall_nxt
);
  logic is_zero;
  assign is_zero = (count_mid == '0);

  always_comb begin
    count_nxt = count_mid;
    data_nxt  = '0;
    valid_nxt = 1'b0;
    stall_nxt = 1'b0;
    if (rd_req) begin
      unique case (rd_view)
        VIEW_RAW: begin
          data_nxt  = count_mid;
          valid_nxt = 1'b1;
        end
        VIEW_TAG: begin
          data_nxt  = {{(W-TW){1'b0}}, tag_mid};
          valid_nxt = 1'b1;
        end
        VIEW_WAIT: begin
          if (is_zero) begin
            stall_nxt = 1'b1;
          end else begin
            data_nxt  = count_mid;
            valid_nxt = 1'b1;
            count_nxt = count_mid - 1'b1;
          end
        end
        default: begin
          data_nxt  = count_mid;
          valid_nxt = 1'b1;
          if (!is_zero) count_nxt = count_mid - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [1:0]       rd_view,
  input  logic             wr_req,
  input  logic [1:0]       wr_view,
  input  logic [CNT_W-1:0] wr_data,
  output logic             rsp_valid,
  output logic             rsp_stall,
  output logic [CNT_W-1:0] rsp_data
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q, count_mid, count_nxt, data_nxt;
  logic [TAG_W-1:0] tag_q, tag_mid;
  logic             tag_load, valid_nxt, stall_nxt;
  logic             cnt_en;

  sem_write_stage #(.W(CNT_W), .TW(TAG_W)) u_wr (
    .wr_req    (wr_req),
    .wr_view   (view_e'(wr_view)),
    .wr_data   (wr_data),
    .count_cur (count_q),
    .tag_cur   (tag_q),
    .count_mid (count_mid),
    .tag_mid   (tag_mid),
    .tag_load  (tag_load)
  );

  sem_read_stage #(.W(CNT_W), .TW(TAG_W)) u_rd (
    .rd_req    (rd_req),
    .rd_view   (view_e'(rd_view)),
    .count_mid (count_mid),
    .tag_mid   (tag_mid),
    .count_nxt (count_nxt),
    .data_nxt  (data_nxt),
    .valid_nxt (valid_nxt),
    .stall_nxt (stall_nxt)
  );

  assign cnt_en = rd_req | wr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_en) begin
      count_q <= count_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (tag_load) begin
      tag_q <= tag_mid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_stall <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= valid_nxt;
      rsp_stall <= stall_nxt;
      rsp_data  <= data_nxt;
    end
  end

  // R5: a stall is never also a completed read
  a_r5_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stall |-> !rsp_valid);

  // R5: polling reads never stall
  a_r5_poll_nostall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_view == VIEW_POLL) |=> !rsp_stall);

  // R6: tags hold unless a tag-view write occurs
  a_r6_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && wr_view == VIEW_TAG) |=> $stable(tag_q));

  // R4: a lone give at the ceiling keeps the ceiling
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && is_pv(view_e'(wr_view)) && !rd_req && count_q == CNT_MAX)
      |=> (count_q == CNT_MAX));

  // R4: a lone give below the ceiling adds exactly one
  a_r4_give_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && is_pv(view_e'(wr_view)) && !rd_req && count_q != CNT_MAX)
      |=> (count_q == $past(count_q) + 1'b1));

  // R3: a take with no write never wraps below zero
  a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !wr_req && count_q == '0) |=> (count_q == '0));

  // R9: idle cycles produce no response
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (!rsp_valid && !rsp_stall));
endmodule

// File: tb/tb_sem_cell.sv
module tb_sem_cell;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_req, wr_req;
  logic [1:0]    rd_view, wr_view;
  logic [W-1:0]  wr_data;
  logic          rsp_valid, rsp_stall;
  logic [W-1:0]  rsp_data;

  always #2 clk = ~clk; // 250 MHz

  sem_cell dut (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_view(rd_view),
    .wr_req(wr_req), .wr_view(wr_view), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_stall(rsp_stall), .rsp_data(rsp_data)
  );

  typedef struct {
    int          due;
    logic        valid;
    logic        stall;
    logic [W-1:0] data;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  logic [W-1:0] m_cnt;
  logic [1:0]   m_tag;

  // monitor: compare outputs shortly after each edge
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (rsp_valid !== e.valid || rsp_stall !== e.stall || rsp_data !== e.data) begin
          errors++;
          $display("FAIL %s: got valid=%0b stall=%0b data=%h, expected valid=%0b stall=%0b data=%h",
                   e.req, rsp_valid, rsp_stall, rsp_data, e.valid, e.stall, e.data);
        end
      end
    end
  end

  // driver: apply one request cycle, push the model's expectation
  task automatic op(input bit rd, input logic [1:0] rv, input bit wr,
                    input logic [1:0] wv, input logic [W-1:0] d, input string req);
    exp_t e;
    logic [W-1:0] mid;
    @(negedge clk);
    rd_req = rd; rd_view = rv; wr_req = wr; wr_view = wv; wr_data = d;
    mid = m_cnt;
    if (wr) begin
      if (wv == 2'd0) mid = d;
      else if (wv == 2'd1) m_tag = d[1:0];
      else mid = (mid == 16'hFFFF) ? mid : mid + 1'b1;
    end
    e.due = cyc + 1; e.valid = 0; e.stall = 0; e.data = '0; e.req = req;
    if (rd) begin
      case (rv)
        2'd0: begin e.valid = 1; e.data = mid; end
        2'd1: begin e.valid = 1; e.data = {14'b0, m_tag}; end
        2'd2: if (mid == 0) e.stall = 1;
              else begin e.valid = 1; e.data = mid; mid = mid - 1'b1; end
        default: begin e.valid = 1; e.data = mid; if (mid != 0) mid = mid - 1'b1; end
      endcase
    end
    m_cnt = mid;
    exp_q.push_back(e);
    @(negedge clk);
    rd_req = 0; wr_req = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rd_req = 0; wr_req = 0; rd_view = 0; wr_view = 0; wr_data = 0;
    m_cnt = 0; m_tag = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (rsp_valid !== 0 || rsp_stall !== 0 || rsp_data !== 0) begin
      errors++;
      $display("FAIL R1: got %b %b %h, expected 0 0 0000", rsp_valid, rsp_stall, rsp_data);
    end
    rst_n = 1;
    op(1, 2'd0, 0, 0, 0, "R1 count zero");
    op(1, 2'd1, 0, 0, 0, "R1 tags zero");
    // R5 waiting read of zero stalls; R3 count stays
    op(1, 2'd2, 0, 0, 0, "R5 wait stall");
    op(1, 2'd0, 0, 0, 0, "R3 floor after stall");
    // R3/R5 polling zero
    op(1, 2'd3, 0, 0, 0, "R3 poll zero");
    op(1, 2'd0, 0, 0, 0, "R3 poll keeps zero");
    // R4 gives
    op(0, 0, 1, 2'd2, 0, "R4 give");
    op(0, 0, 1, 2'd3, 0, "R4 give");
    op(0, 0, 1, 2'd2, 0, "R4 give");
    op(1, 2'd0, 0, 0, 0, "R4 count three");
    // R2 takes
    op(1, 2'd2, 0, 0, 0, "R2 wait take");
    op(1, 2'd3, 0, 0, 0, "R2 poll take");
    op(1, 2'd0, 0, 0, 0, "R2 count one");
    // R7 raw load and read
    op(0, 0, 1, 2'd0, 16'hFFFE, "R7 raw load");
    op(1, 2'd0, 0, 0, 0, "R7 raw read");
    op(1, 2'd0, 0, 0, 0, "R7 raw read no change");
    // R4 saturate
    op(0, 0, 1, 2'd2, 0, "R4 to max");
    op(0, 0, 1, 2'd3, 0, "R4 past max");
    op(1, 2'd0, 0, 0, 0, "R4 saturated");
    // R8 at ceiling: give saturates then take
    op(1, 2'd2, 1, 2'd2, 0, "R8 ceiling pair");
    op(1, 2'd0, 0, 0, 0, "R8 after ceiling pair");
    // R8 at floor: give then waiting take succeeds
    op(0, 0, 1, 2'd0, 16'h0000, "R7 raw clear");
    op(1, 2'd2, 1, 2'd3, 0, "R8 floor pair");
    op(1, 2'd0, 0, 0, 0, "R8 floor after");
    // R8 raw write with take in same cycle
    op(1, 2'd3, 1, 2'd0, 16'h0010, "R8 raw plus take");
    op(1, 2'd0, 0, 0, 0, "R8 raw plus take count");
    // R6 tags
    op(0, 0, 1, 2'd1, 16'hFFFE, "R6 tag write");
    op(1, 2'd1, 0, 0, 0, "R6 tag read");
    op(1, 2'd0, 0, 0, 0, "R6 count untouched by tag write");
    op(1, 2'd2, 1, 2'd2, 0, "R6 pv ops");
    op(0, 0, 1, 2'd0, 16'h1234, "R6 raw op");
    op(1, 2'd1, 0, 0, 0, "R6 tags held");
    op(1, 2'd1, 1, 2'd1, 16'h0001, "R6 tag write then read");
    // R9 idle cycle has no response
    exp_q.push_back('{cyc + 1, 1'b0, 1'b0, 16'h0, "R9 idle"});
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule